// File: doc/BRIEF.md
# Deep-Sleep Wake-Source Status Register

This block holds a 16-bit status word that tells software why the chip came back from its deepest low-power sleep state. Five wake causes are captured as sticky flags, and each flag is recorded only while the deep-sleep indicator is high. The causes are a pin-change interrupt, a configuration fault, a watchdog timeout, a real-time-clock alarm and an assertion of the external reset pin. A sixth flag records a supply power-on-reset detection. That flag has its own rules: it may be set at any time, and a reset caused by leaving deep sleep does not clear it.

The event inputs are asynchronous. Each passes through a synchronizer and a rising-edge detector, so one event sets its flag once, however long the input stays high. Software reads the word continuously on `rd_data_o`. It clears flags by writing zeros through a single-cycle write port. All flags are also wiped when software arms deep sleep (`dsen_set_i`) and when a power-on reset occurs outside deep sleep.

Top module: `dswake_status`

## Requirements
- R1: The implemented bits are: 8 pin-change interrupt, 7 configuration fault, 4 watchdog timeout, 3 clock alarm, 2 reset-pin event and 0 power-on reset. Every other bit of `rd_data_o` always reads 0.
- R2: A rising edge on `ioc_evt_i`, `fault_evt_i`, `wdt_evt_i` or `rtc_evt_i` sets its flag only if `ds_active_i` is 1 when the edge is captured. The flag is visible after the third rising clock edge that follows the input going high, and it stays set until it is cleared.
- R3: A rising edge on `pin_rst_i` sets bit 2 only if both `ds_active_i` and `pin_en_i` are 1. If the pin is enabled but never pulsed, bit 2 stays 0.
- R4: A one-cycle pulse on `dsen_set_i` clears every flag, including bit 0.
- R5: A pulse on `por_rst_i` with `por_ds_exit_i`=0 clears every flag. A pulse with `por_ds_exit_i`=1 changes no flag.
- R6: A rising edge on `por_det_i` sets bit 0 with the same latency as R2, whatever the value of `ds_active_i`.
- R7: While `rst_n` is low, all flags are 0.
- R8: A cycle with `wr_en_i`=1 clears each implemented bit whose `wr_data_i` bit is 0. Bits written 1, and all unimplemented bits, are left unchanged.
- R9: When a hardware set and a software write of 0 reach the same flag in the same cycle, the flag ends up set.
- R10: When `dsen_set_i` and a captured event fall in the same cycle, all other flags clear and the event's flag ends up set.
- R11: An input held high produces one capture only. Once its flag has been cleared, it stays clear until the input falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears all flags |
| ds_active_i | input | 1 | High while the chip is in deep sleep |
| ioc_evt_i | input | 1 | Pin-change interrupt event, asynchronous |
| fault_evt_i | input | 1 | Configuration fault event, asynchronous |
| wdt_evt_i | input | 1 | Deep-sleep watchdog timeout, asynchronous |
| rtc_evt_i | input | 1 | Real-time-clock alarm, asynchronous |
| pin_rst_i | input | 1 | External reset pin asserted, asynchronous |
| pin_en_i | input | 1 | External reset pin function enabled |
| por_det_i | input | 1 | Supply power-on-reset detected (detector enabled), asynchronous |
| por_rst_i | input | 1 | Power-on-reset strobe, synchronous |
| por_ds_exit_i | input | 1 | Tags `por_rst_i` as caused by leaving deep sleep |
| dsen_set_i | input | 1 | Software set the deep-sleep enable bit (strobe) |
| wr_en_i | input | 1 | Status write strobe |
| wr_data_i | input | 16 | Write data; a 0 clears the flag in that position |
| rd_data_o | output | 16 | Status word |

## Verification
The assertions assume that `ds_active_i`, `pin_en_i`, `por_rst_i`, `por_ds_exit_i`, `dsen_set_i` and the write port are synchronous to `clk`. Only the six event inputs may change at any time. The bench drives every input on the falling edge. It holds `ds_active_i` and `pin_en_i` steady from before an event rises until well after its capture. It also times the same-cycle collision cases from the known three-edge capture latency, so that a strobe lands on the capture cycle.

// File: rtl/dswake_pkg.sv
package dswake_pkg;
    localparam int REG_W = 16;
    localparam int N_EV  = 5;

    localparam int B_IOC = 8;
    localparam int B_FLT = 7;
    localparam int B_WDT = 4;
    localparam int B_RTC = 3;
    localparam int B_PIN = 2;
    localparam int B_POR = 0;
    localparam int EV_PIN = 4;

    localparam logic [REG_W-1:0] IMPL_MASK =
        (REG_W'(1) << B_IOC) | (REG_W'(1) << B_FLT) | (REG_W'(1) << B_WDT) |
        (REG_W'(1) << B_RTC) | (REG_W'(1) << B_PIN) | (REG_W'(1) << B_POR);

    function automatic int ev_bit(input int idx);
        case (idx)
            0:       return B_IOC;
            1:       return B_FLT;
            2:       return B_WDT;
            3:       return B_RTC;
            default: return B_PIN;
        endcase
    endfunction

    typedef struct packed {
        logic [REG_W-1:0] flags;
    } wake_state_t;
endpackage

// File: rtl/dswake_sync.sv
module dswake_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise_o = sh_q[LAST] & ~sh_q[STAGES];

    // R11: one capture per rising edge of the input
    p_single_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/dswake_status.sv
module dswake_status
    import dswake_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ds_active_i,
    input  logic             ioc_evt_i,
    input  logic             fault_evt_i,
    input  logic             wdt_evt_i,
    input  logic             rtc_evt_i,
    input  logic             pin_rst_i,
    input  logic             pin_en_i,
    input  logic             por_det_i,
    input  logic             por_rst_i,
    input  logic             por_ds_exit_i,
    input  logic             dsen_set_i,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic [REG_W-1:0] rd_data_o
);
    logic [N_EV-1:0]  ev_raw, ev_rise;
    logic             por_rise;
    logic [REG_W-1:0] set_vec;
    logic             wipe;
    wake_state_t      st_d, st_q;

    assign ev_raw = {pin_rst_i, rtc_evt_i, wdt_evt_i, fault_evt_i, ioc_evt_i};

    for (genvar i = 0; i < N_EV; i++) begin : g_ev
        dswake_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk(clk), .rst_n(rst_n), .async_i(ev_raw[i]), .rise_o(ev_rise[i])
        );
    end

    dswake_sync #(.STAGES(SYNC_STAGES)) u_por_sync (
        .clk(clk), .rst_n(rst_n), .async_i(por_det_i), .rise_o(por_rise)
    );

    // Event gating: deep sleep for all, pin enable for the reset pin
    always_comb begin
        set_vec = '0;
        for (int i = 0; i < N_EV; i++) begin
            set_vec[ev_bit(i)] = ev_rise[i] & ds_active_i & ((i != EV_PIN) | pin_en_i);
        end
        set_vec[B_POR] = por_rise;
    end

    assign wipe = dsen_set_i | (por_rst_i & ~por_ds_exit_i);

    // Clears first, hardware sets last
    always_comb begin
        st_d = st_q;
        if (wipe)    st_d.flags = '0;
        if (wr_en_i) st_d.flags = st_d.flags & (wr_data_i | ~IMPL_MASK);
        st_d.flags = (st_d.flags | set_vec) & IMPL_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data_o = st_q.flags;

    p_unimpl_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_o & ~IMPL_MASK) == '0);

    for (genvar i = 0; i < N_EV; i++) begin : g_chk
        localparam int BP = ev_bit(i);
        p_sleep_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (!$past(st_q.flags[BP]) && st_q.flags[BP]) |-> $past(ds_active_i));
    end

    p_pin_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(st_q.flags[B_PIN]) && st_q.flags[B_PIN]) |-> $past(pin_en_i));

    p_dsen_wipe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dsen_set_i) && $past(set_vec) == '0) |-> (st_q.flags == '0));

    p_exit_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(por_rst_i && por_ds_exit_i && !dsen_set_i && !wr_en_i)
        |-> (($past(st_q.flags) & ~st_q.flags) == '0));

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(set_vec) & ~st_q.flags) == '0);
endmodule

// File: tb/dswake_status_test.sv
module dswake_status_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ds_active = 1'b0;
    logic [4:0]  ev = '0;
    logic        pin_en = 1'b0;
    logic        por_det = 1'b0;
    logic        por_rst = 1'b0;
    logic        por_exit = 1'b0;
    logic        dsen = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_q = '0;

    localparam logic [15:0] MASK = 16'h019D;
    int bitpos [5] = '{8, 7, 4, 3, 2};

    always #4 clk = ~clk;

    dswake_status uut (
        .clk(clk), .rst_n(rst_n), .ds_active_i(ds_active),
        .ioc_evt_i(ev[0]), .fault_evt_i(ev[1]), .wdt_evt_i(ev[2]),
        .rtc_evt_i(ev[3]), .pin_rst_i(ev[4]), .pin_en_i(pin_en),
        .por_det_i(por_det), .por_rst_i(por_rst), .por_ds_exit_i(por_exit),
        .dsen_set_i(dsen), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .rd_data_o(rd_data)
    );

    task automatic check(input string tag);
        checks++;
        if (rd_data !== exp_q) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, rd_data, exp_q);
        end
    endtask

    task automatic fire(input int idx, input logic ds, input logic en);
        @(negedge clk); ds_active = ds; pin_en = en;
        @(negedge clk); ev[idx] = 1'b1;
        @(negedge clk); ev[idx] = 1'b0;
        repeat (3) @(negedge clk);
        if (ds && (idx != 4 || en)) exp_q |= 16'(1) << bitpos[idx];
        ds_active = 1'b0;
    endtask

    task automatic fire_por();
        @(negedge clk); por_det = 1'b1;
        @(negedge clk); por_det = 1'b0;
        repeat (3) @(negedge clk);
        exp_q |= 16'h0001;
    endtask

    task automatic set_all();
        for (int i = 0; i < 5; i++) fire(i, 1'b1, 1'b1);
        fire_por();
    endtask

    task automatic dsen_pulse();
        @(negedge clk); dsen = 1'b1;
        @(negedge clk); dsen = 1'b0;
        exp_q = '0;
    endtask

    task automatic write(input logic [15:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
        exp_q &= (d | ~MASK);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R7 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle zero");

        // R2 / R3 sweep over event, sleep state, pin enable
        for (int idx = 0; idx < 5; idx++) begin
            for (int ds = 0; ds < 2; ds++) begin
                for (int en = 0; en < 2; en++) begin
                    dsen_pulse();
                    check("R4 clear before sweep");
                    fire(idx, ds[0], en[0]);
                    check(idx == 4 ? "R3 pin event gating" : "R2 sleep-gated event");
                    checks++;
                    if ((rd_data & ~MASK) != 0) begin
                        errors++;
                        $display("FAIL R1: got %h expected %h", rd_data & ~MASK, 16'h0);
                    end
                end
            end
        end

        // R3: pin enabled in sleep but never pulsed
        dsen_pulse();
        @(negedge clk); ds_active = 1'b1; pin_en = 1'b1;
        repeat (6) @(negedge clk);
        ds_active = 1'b0;
        check("R3 enabled but not asserted");

        // R8 write sweep
        for (int b = 0; b < 16; b++) begin
            set_all();
            check("R2 all flags set");
            write(~(16'(1) << b));
            check("R8 write zero clears one bit");
        end
        set_all();
        write(16'hFFFF);
        check("R8 write ones no effect");

        // R6 power-on detection outside sleep
        dsen_pulse();
        fire_por();
        check("R6 por flag outside sleep");

        // R5
        set_all();
        @(negedge clk); por_rst = 1'b1; por_exit = 1'b1;
        @(negedge clk); por_rst = 1'b0; por_exit = 1'b0;
        check("R5 exit reset keeps flags");
        @(negedge clk); por_rst = 1'b1;
        @(negedge clk); por_rst = 1'b0;
        exp_q = '0;
        check("R5 plain reset clears");

        // R9 set beats same-cycle write of zero
        set_all();
        @(negedge clk); ds_active = 1'b1;
        @(negedge clk); ev[2] = 1'b1;
        @(negedge clk); ev[2] = 1'b0;
        @(negedge clk); wr_en = 1'b1; wr_data = 16'h0000;
        @(negedge clk); wr_en = 1'b0; ds_active = 1'b0;
        exp_q = 16'h0010;
        check("R9 hardware set wins");

        // R10 enable clear with simultaneous event
        set_all();
        @(negedge clk); ds_active = 1'b1;
        @(negedge clk); ev[0] = 1'b1;
        @(negedge clk); ev[0] = 1'b0;
        @(negedge clk); dsen = 1'b1;
        @(negedge clk); dsen = 1'b0; ds_active = 1'b0;
        exp_q = 16'h0100;
        check("R10 event kept over enable clear");

        // R11 held input captured once
        dsen_pulse();
        @(negedge clk); ds_active = 1'b1;
        @(negedge clk); ev[3] = 1'b1;
        repeat (4) @(negedge clk);
        exp_q = 16'h0008;
        check("R11 held input sets");
        write(16'h0000);
        repeat (6) @(negedge clk);
        check("R11 held input does not re-set");
        ev[3] = 1'b0;
        ds_active = 1'b0;
        repeat (4) @(negedge clk);
        check("R11 after release");

        // R7 asynchronous reset mid-run
        set_all();
        #1 rst_n = 1'b0;
        #2 exp_q = '0;
        check("R7 async reset clears");
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R7 after release");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule